// File: doc/BRIEF.md
# Byte-Interleaving Backplane Burst Sequencer

The sequencer merges four 2.048 Mb/s serial PCM tributaries into one 8.192 Mb/s backplane stream, one byte at a time. It runs on the 8.192 MHz backplane bit clock and emits three things:

- a frame marker that all four sources share;
- one clock-enable per source;
- the registered backplane data bit.

Each source sees its enable high for exactly eight consecutive bit times and then low while the other three take their turn. An unmodified source that shifts one bit per enabled cycle therefore hands over one complete 8-bit timeslot per burst.

The frame is 125 µs long, which is 1024 bit times. That gives 128 byte slots, and every source owns 32 of them. Slot n always belongs to source n mod 4. A two-state controller sequences the block:

- **ST_HOLD** is entered by reset. The position counter is held at bit 0 of slot 0 and every output is low.
- **ST_RUN** is reached through the transition *hold_release*, one cycle after reset is released. In this state the counter advances every cycle.
- The transition *run_loop* keeps the controller in ST_RUN.
- The transition *reset_abort* returns the controller from either state to ST_HOLD whenever reset is sampled high.

Top module: `bp_burst_seq`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the next cycle shows `frame_sync`=0, `burst_en`=0 and `bp_data`=0.
- R2: After `rst` is released, one cycle passes with all outputs low (ST_HOLD). The first `frame_sync` pulse comes in the cycle after that, and no `burst_en` bit is high before it.
- R3: Once running, `frame_sync` is high for exactly one cycle in every 1024 cycles.
- R4: In every running cycle exactly one bit of `burst_en` is high.
- R5: Each high period of a `burst_en` bit lasts exactly 8 consecutive cycles.
- R6: Sources are served in the order 0, 1, 2, 3, repeating. Byte slot n (counted from the `frame_sync` cycle, 8 cycles per slot) has `burst_en` bit (n mod 4) set, so bit 0 is high in the `frame_sync` cycle.
- R7: In the cycle after a running cycle, `bp_data` equals the `trib_data` bit of the source whose `burst_en` bit was high in that running cycle, as sampled at the edge between them. In the cycle after an ST_HOLD cycle, `bp_data` is 0.
- R8: A reset applied in mid-frame abandons the current position. The controller returns to ST_HOLD and restarts at slot 0, bit 0 with the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8.192 MHz backplane bit clock |
| rst | input | 1 | Synchronous reset, active high |
| trib_data | input | 4 | Serial data bit from each tributary source |
| frame_sync | output | 1 | One-cycle frame marker at slot 0, bit 0 |
| burst_en | output | 4 | Per-source clock enable, one-hot while running |
| bp_data | output | 1 | Registered byte-interleaved backplane data |

## Verification
A corrupted slot or bit count shows at the ports within one slot (8 cycles) as a burst of the wrong length or a skipped source. A wrong frame wrap shows within one frame (1024 cycles) as a misplaced `frame_sync`. A stale or wrong source select corrupts `bp_data` on the very next cycle, because each bit comes from a single register stage. A controller stuck in ST_HOLD, or a reset that does not abort, is visible two cycles after release through the missing first `frame_sync`.

// File: rtl/bp_burst_pkg.sv
package bp_burst_pkg;

    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/bp_slot_counter.sv
module bp_slot_counter #(
    parameter int SLOT_BITS   = 8,
    parameter int FRAME_SLOTS = 128,
    localparam int BIT_W      = $clog2(SLOT_BITS),
    localparam int SLOT_W     = $clog2(FRAME_SLOTS)
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              advance,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              at_frame_start
);

    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(SLOT_BITS - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_SLOTS - 1);

    always_ff @(posedge clk) begin
        if (clear) begin
            bit_idx  <= '0;
            slot_idx <= '0;
        end else if (advance) begin
            if (bit_idx == BIT_LAST) begin
                bit_idx  <= '0;
                slot_idx <= (slot_idx == SLOT_LAST) ? '0 : slot_idx + 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    always_comb begin
        at_frame_start = (bit_idx == '0) && (slot_idx == '0);
    end

endmodule

// File: rtl/bp_burst_gate.sv
module bp_burst_gate #(
    parameter int NUM_TRIB    = 4,
    parameter int FRAME_SLOTS = 128,
    localparam int TRIB_W     = $clog2(NUM_TRIB),
    localparam int SLOT_W     = $clog2(FRAME_SLOTS)
) (
    input  logic                running,
    input  logic [SLOT_W-1:0]   slot_idx,
    output logic [NUM_TRIB-1:0] enables,
    output logic [TRIB_W-1:0]   active_idx
);

    // Slot count and source count are powers of two, so the low bits of
    // the slot number select the source.
    always_comb begin
        active_idx = slot_idx[TRIB_W-1:0];
    end

    for (genvar g = 0; g < NUM_TRIB; g++) begin : g_gate
        always_comb begin
            enables[g] = running && (active_idx == TRIB_W'(g));
        end
    end

endmodule

// File: rtl/bp_data_mux.sv
module bp_data_mux #(
    parameter int NUM_TRIB = 4,
    localparam int TRIB_W  = $clog2(NUM_TRIB)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                running,
    input  logic [TRIB_W-1:0]   active_idx,
    input  logic [NUM_TRIB-1:0] trib_data,
    output logic                bp_data
);

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            bp_data <= 1'b0;
        end else begin
            bp_data <= trib_data[active_idx];
        end
    end

endmodule

// File: rtl/bp_burst_seq.sv
module bp_burst_seq
    import bp_burst_pkg::*;
#(
    parameter int NUM_TRIB    = 4,
    parameter int SLOT_BITS   = 8,
    parameter int FRAME_SLOTS = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TRIB-1:0] trib_data,
    output logic                frame_sync,
    output logic [NUM_TRIB-1:0] burst_en,
    output logic                bp_data
);

    localparam int TRIB_W = $clog2(NUM_TRIB);
    localparam int BIT_W  = $clog2(SLOT_BITS);
    localparam int SLOT_W = $clog2(FRAME_SLOTS);

    seq_state_t state_q;
    seq_state_t state_d;

    logic              running;
    logic              cnt_clear;
    logic [BIT_W-1:0]  bit_idx;
    logic [SLOT_W-1:0] slot_idx;
    logic              at_frame_start;
    logic [TRIB_W-1:0] active_idx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: hold_release from ST_HOLD, run_loop in ST_RUN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_HOLD;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        running    = 1'b0;
        cnt_clear  = 1'b1;
        unique case (state_q)
            ST_HOLD: begin
                running   = 1'b0;
                cnt_clear = 1'b1;
            end
            ST_RUN: begin
                running   = 1'b1;
                cnt_clear = rst;
            end
            default: begin
                running   = 1'b0;
                cnt_clear = 1'b1;
            end
        endcase
        frame_sync = running && at_frame_start;
    end

    bp_slot_counter #(
        .SLOT_BITS   (SLOT_BITS),
        .FRAME_SLOTS (FRAME_SLOTS)
    ) u_counter (
        .clk            (clk),
        .clear          (cnt_clear | rst),
        .advance        (running),
        .bit_idx        (bit_idx),
        .slot_idx       (slot_idx),
        .at_frame_start (at_frame_start)
    );

    bp_burst_gate #(
        .NUM_TRIB    (NUM_TRIB),
        .FRAME_SLOTS (FRAME_SLOTS)
    ) u_gate (
        .running    (running),
        .slot_idx   (slot_idx),
        .enables    (burst_en),
        .active_idx (active_idx)
    );

    bp_data_mux #(
        .NUM_TRIB (NUM_TRIB)
    ) u_mux (
        .clk        (clk),
        .rst        (rst),
        .running    (running),
        .active_idx (active_idx),
        .trib_data  (trib_data),
        .bp_data    (bp_data)
    );

endmodule

// File: rtl/bp_burst_seq_chk.sv
module bp_burst_seq_chk #(
    parameter int NUM_TRIB    = 4,
    parameter int SLOT_BITS   = 8,
    parameter int FRAME_SLOTS = 128
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_TRIB-1:0] trib_data,
    input logic                frame_sync,
    input logic [NUM_TRIB-1:0] burst_en,
    input logic                bp_data
);

    localparam int FRAME_BITS = SLOT_BITS * FRAME_SLOTS;
    localparam int FRM_W      = $clog2(FRAME_BITS) + 1;
    localparam int RUN_W      = $clog2(SLOT_BITS) + 1;

    logic                seen_sync;
    logic                prev_run;
    logic                prev_bit;
    logic [NUM_TRIB-1:0] prev_en;
    logic [FRM_W-1:0]    frm_cnt;
    logic [RUN_W-1:0]    run_cnt;
    logic                live;

    always_comb begin
        live = seen_sync || frame_sync;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_sync <= 1'b0;
            prev_run  <= 1'b0;
            prev_bit  <= 1'b0;
            prev_en   <= '0;
            frm_cnt   <= '0;
            run_cnt   <= '0;
        end else begin
            seen_sync <= live;
            prev_run  <= live;
            prev_bit  <= |(burst_en & trib_data);
            prev_en   <= burst_en;
            if (frame_sync) begin
                frm_cnt <= '0;
            end else if (frm_cnt != '1) begin
                frm_cnt <= frm_cnt + 1'b1;
            end
            if (burst_en != prev_en) begin
                run_cnt <= '0;
            end else if (run_cnt != '1) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // R1 / R8: reset leaves every output low in the next cycle
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!frame_sync && burst_en == '0 && !bp_data));

    // R2: no enable before the first frame marker
    p_quiet_before_sync_r2: assert property (@(posedge clk) disable iff (rst)
        !live |-> (burst_en == '0));

    // R3: frame marker period
    p_sync_period_r3: assert property (@(posedge clk) disable iff (rst)
        seen_sync |-> (frame_sync == (frm_cnt == FRM_W'(FRAME_BITS - 1))));

    // R4: one source enabled at a time while running
    p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        live |-> ($countones(burst_en) == 1));

    // R5: burst length never exceeds a slot
    p_burst_max_r5: assert property (@(posedge clk) disable iff (rst)
        seen_sync |-> (run_cnt < RUN_W'(SLOT_BITS)));

    // R5 / R6: hand-over after exactly one slot, to the next source in order
    p_handover_r6: assert property (@(posedge clk) disable iff (rst)
        (seen_sync && prev_en != '0 && burst_en != prev_en) |->
        (run_cnt == RUN_W'(SLOT_BITS - 1) &&
         burst_en == {prev_en[NUM_TRIB-2:0], prev_en[NUM_TRIB-1]}));

    // R6: source 0 owns the frame start
    p_sync_src0_r6: assert property (@(posedge clk) disable iff (rst)
        frame_sync |-> burst_en[0]);

    // R7: backplane bit follows the enabled source by one cycle
    p_data_path_r7: assert property (@(posedge clk) disable iff (rst)
        prev_run |-> (bp_data == prev_bit));

endmodule

bind bp_burst_seq bp_burst_seq_chk #(
    .NUM_TRIB    (NUM_TRIB),
    .SLOT_BITS   (SLOT_BITS),
    .FRAME_SLOTS (FRAME_SLOTS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .trib_data  (trib_data),
    .frame_sync (frame_sync),
    .burst_en   (burst_en),
    .bp_data    (bp_data)
);

// File: tb/bp_burst_seq_bench.sv
module bp_burst_seq_bench;

    localparam int NT         = 4;
    localparam int FRAME_BITS = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NT-1:0] trib_data = '0;
    logic          frame_sync;
    logic [NT-1:0] burst_en;
    logic          bp_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model
    bit      m_run;
    int      m_pos;
    bit      m_data;
    bit      m_after_mid;
    bit      m_in_rst;
    logic [NT-1:0] last_en;
    int      run_len;

    always #2.5 clk = ~clk;

    bp_burst_seq u_bp_burst_seq (
        .clk        (clk),
        .rst        (rst),
        .trib_data  (trib_data),
        .frame_sync (frame_sync),
        .burst_en   (burst_en),
        .bp_data    (bp_data)
    );

    function automatic logic [NT-1:0] exp_en(bit run, int pos);
        if (!run) return '0;
        return NT'(1) << ((pos / 8) % NT);
    endfunction

    function automatic bit exp_sync(bit run, int pos);
        return run && (pos == 0);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string hold_tag();
        if (m_in_rst) return "R1";
        if (m_after_mid) return "R8";
        return "R2";
    endfunction

    // one cycle: check outputs at the negedge, then drive the next inputs
    task automatic step(bit r, logic [NT-1:0] d);
        @(negedge clk);
        if (!m_run) begin
            check({hold_tag(), " sync"}, frame_sync, 0);
            check({hold_tag(), " en"}, burst_en, 0);
            check({hold_tag(), " data"}, bp_data, 0);
        end else begin
            check("R3 sync", frame_sync, exp_sync(m_run, m_pos));
            check("R6 en", burst_en, exp_en(m_run, m_pos));
            check("R4 onehot", $countones(burst_en), 1);
            check("R7 data", bp_data, m_data);
            if (burst_en != last_en) begin
                if (last_en != '0) check("R5 burst length", run_len, 8);
                run_len = 1;
            end else begin
                run_len++;
            end
        end
        last_en = burst_en;
        rst = r;
        trib_data = d;
        // model of the coming edge
        if (r) begin
            m_run = 0; m_pos = 0; m_data = 0; m_in_rst = 1;
            last_en = '0; run_len = 0;
        end else if (!m_run) begin
            m_run = 1; m_pos = 0; m_data = 0; m_in_rst = 0;
        end else begin
            m_data = d[(m_pos / 8) % NT];
            m_pos = (m_pos + 1) % FRAME_BITS;
            m_after_mid = 0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed;
        logic [NT-1:0] d;
        seed = 32'h5eed_b00c;
        void'($urandom(seed));
        m_run = 0; m_pos = 0; m_data = 0; m_after_mid = 0; m_in_rst = 1;
        last_en = '0; run_len = 0;
        // settle the registers under reset
        repeat (2) @(negedge clk);
        // R1: reset held for a few checked cycles
        for (int i = 0; i < 3; i++) step(1'b1, 4'hF);
        // R2/R3/R6/R7: two and a half frames of random data
        for (int i = 0; i < 2600; i++) step(1'b0, NT'($urandom()));
        // R8: mid-frame reset for one cycle
        m_after_mid = 1;
        step(1'b1, '0);
        m_after_mid = 1;
        for (int i = 0; i < 1500; i++) step(1'b0, NT'($urandom()));
        // R7 directed: only one source drives ones, per pass
        for (int s = 0; s < NT; s++) begin
            for (int i = 0; i < 64; i++) step(1'b0, NT'(1) << s);
        end
        // R7 directed: all ones then all zeros
        for (int i = 0; i < 40; i++) step(1'b0, '1);
        for (int i = 0; i < 40; i++) step(1'b0, '0);
        // R8: longer reset in the middle of a burst
        m_after_mid = 1;
        for (int i = 0; i < 4; i++) step(1'b1, '1);
        m_after_mid = 1;
        for (int i = 0; i < 2200; i++) begin
            d = NT'($urandom());
            step(1'b0, d);
        end
        finish_run();
    end

endmodule